// File: doc/BRIEF.md
# Two-Channel Descriptor DMA Engine

This block copies bytes between two memory spaces, a local space and a PCI-side space, through one word-wide memory master port. It has two channels that run independently. Each channel can copy in any of the four space combinations. A channel runs in one of two modes. In direct mode it performs one programmed copy. In chained mode it fetches four-word descriptors from local memory and follows the next-descriptor links until it reaches a descriptor marked as last, which gives scatter-gather transfers.

Start and end addresses can fall on any byte, and the length is counted in bytes. Each memory step covers the largest chunk that stays inside both the current source word and the current destination word. A byte-lane shifter moves the data to the correct lanes, and byte enables mark the lanes that are written. A local-space window holds read-only ROM, and a write that would land in that window stops the channel with an error. The two channels share the port through a round-robin arbiter that switches at word boundaries. Each channel raises three interrupt lines: segment done, chain done and error.

Top module: `dma_engine`

## Requirements
- R1: After reset, every status register reads 0, all interrupt lines are low and `mem_req` is low.
- R2: Register map. `reg_addr[3]` selects the channel. `reg_addr[2:0]` selects the register: 0 is control, 1 is source, 2 is destination, 3 is next-descriptor, 4 is byte count and 5 is status. In the control register, bit 0 starts the channel, bit 1 selects chained mode, bit 2 sets the source space to PCI and bit 3 sets the destination space to PCI (a 0 in bit 2 or 3 selects local). Control reads back bits 3:1. The other registers read back their values.
- R3: A direct transfer copies exactly `count` bytes from source to destination. This holds for all four space combinations.
- R4: Source address, destination address and count may each have any byte alignment. Destination bytes outside the range being written keep their values.
- R5: In chained mode the first descriptor is read from local space at the next-descriptor register with bits 1:0 cleared. A descriptor is four words: source at offset 0, destination at 4, next pointer at 8 and byte count at 12. Bit 0 of the next pointer marks the last descriptor. All segments use the spaces set in the control register.
- R6: A write to local space inside [ROM_BASE, ROM_BASE+ROM_SIZE) is never issued. At the point of that write the channel sets its error bit and clears busy. Bytes written before that point stay written.
- R7: A control write while the channel is busy is ignored, and so is a write to its source, destination, next or count register while busy.
- R8: A segment with a count of zero completes (segment done) without any memory access.
- R9: Status layout: bit 0 is busy (read-only), bit 1 is segment done, bit 2 is chain done and bit 3 is error. Writing 1 to bit 1, 2 or 3 clears that bit and leaves the others unchanged.
- R10: The `irq_seg`, `irq_chain` and `irq_err` lines of each channel follow that channel's status bits 1, 2 and 3. Segment done is set at the end of every segment, in both modes. Chain done is set only when a chained run reaches its last descriptor.
- R11: Every write access carries a nonzero byte enable that covers only the lanes being written. Partial words are written with partial enables.
- R12: When both channels request the port, the grants alternate between them one word access at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Channel select in bit 3, register index in bits 2:0 |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request, held until granted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_space | output | 1 | 0 = local space, 1 = PCI space |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Access accepted in this cycle |
| mem_rdata | input | 32 | Read data, valid with the grant |
| irq_seg | output | 2 | Segment-done interrupt, one per channel |
| irq_chain | output | 2 | Chain-done interrupt, one per channel |
| irq_err | output | 2 | Error interrupt, one per channel |

## Verification
The bench builds the engine with the ROM window moved down to local bytes 0x300 to 0x3FF. With the window that low, a 1 KB model memory can hold both a transfer that runs into the window partway through and one that starts inside it. The bench compares the full contents of both model spaces against a byte-level reference copy. Misaligned, partial and chained copies are therefore checked byte by byte, including the bytes just outside each destination range. The model withholds the grant on one cycle in four, so requests stall and the two channels interleave during the concurrent run.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        CH_IDLE, CH_FETCH, CH_SEG, CH_READ, CH_WRITE, CH_END
    } ch_state_e;

    localparam logic [2:0] REG_CTRL  = 3'd0;
    localparam logic [2:0] REG_SRC   = 3'd1;
    localparam logic [2:0] REG_DST   = 3'd2;
    localparam logic [2:0] REG_NEXT  = 3'd3;
    localparam logic [2:0] REG_COUNT = 3'd4;
    localparam logic [2:0] REG_STAT  = 3'd5;

    typedef struct packed {
        logic        req;
        logic        we;
        logic        space;
        logic [31:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
    } port_req_t;

    // Bytes movable in one step: bounded by source word, destination word and count.
    function automatic logic [2:0] chunk_len(input logic [1:0] sl, input logic [1:0] dl,
                                             input logic [31:0] cnt);
        logic [2:0] a;
        a = 3'd4 - {1'b0, sl};
        if ((3'd4 - {1'b0, dl}) < a) a = 3'd4 - {1'b0, dl};
        if (cnt < 32'(a)) a = cnt[2:0];
        return a;
    endfunction

    function automatic logic in_window(input logic [31:0] addr, input logic [31:0] base,
                                       input logic [31:0] size);
        return (addr >= base) && ((addr - base) < size);
    endfunction

endpackage

// File: rtl/dma_lane_shift.sv
module dma_lane_shift (
    input  logic [31:0] data_in,
    input  logic [1:0]  src_lane,
    input  logic [1:0]  dst_lane,
    input  logic [2:0]  nbytes,
    output logic [31:0] data_out,
    output logic [3:0]  lane_en
);
    logic [1:0] up_amt, dn_amt;
    logic [4:0] run_mask;

    always_comb begin
        up_amt = dst_lane - src_lane;
        dn_amt = src_lane - dst_lane;
        if (dst_lane >= src_lane) data_out = data_in << {up_amt, 3'b000};
        else                      data_out = data_in >> {dn_amt, 3'b000};
        run_mask = (5'd1 << nbytes) - 5'd1;
        lane_en  = run_mask[3:0] << dst_lane;
    end
endmodule

// File: rtl/dma_rr_arb.sv
module dma_rr_arb (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] req,
    input  logic       port_gnt,
    output logic [1:0] sel
);
    logic last_one;

    always_comb begin
        case (req)
            2'b01:   sel = 2'b01;
            2'b10:   sel = 2'b10;
            2'b11:   sel = last_one ? 2'b01 : 2'b10;
            default: sel = 2'b00;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) last_one <= 1'b1;
        else if (port_gnt && (sel != 2'b00)) last_one <= sel[1];
    end

    a_r12_alternate: assert property (@(posedge clk) disable iff (rst)
        (req == 2'b11 && port_gnt && sel == 2'b01) ##1 (req == 2'b11) |-> sel == 2'b10);
    a_r12_alternate_b: assert property (@(posedge clk) disable iff (rst)
        (req == 2'b11 && port_gnt && sel == 2'b10) ##1 (req == 2'b11) |-> sel == 2'b01);
    a_r12_one_grant: assert property (@(posedge clk) disable iff (rst) $onehot0(sel));
endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_pkg::*;
#(
    parameter logic [31:0] ROM_BASE = 32'hFF00_0000,
    parameter logic [31:0] ROM_SIZE = 32'h0100_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [2:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        port_gnt,
    input  logic [31:0] port_rdata,
    output port_req_t   port_out,
    output logic        irq_seg,
    output logic        irq_chain,
    output logic        irq_err
);
    ch_state_e   state;
    logic [31:0] src, dst, nxt, cnt, dbase, hold;
    logic        chain_mode, src_pci, dst_pci, busy;
    logic        st_seg, st_chain, st_err;
    logic [1:0]  fidx;
    logic [2:0]  step_n;
    logic        rom_hit;
    logic [31:0] sh_data;
    logic [3:0]  sh_be;

    assign step_n  = chunk_len(src[1:0], dst[1:0], cnt);
    assign rom_hit = !dst_pci && in_window(dst, ROM_BASE, ROM_SIZE);

    dma_lane_shift shift_i (
        .data_in(hold), .src_lane(src[1:0]), .dst_lane(dst[1:0]),
        .nbytes(step_n), .data_out(sh_data), .lane_en(sh_be)
    );

    always_comb begin
        port_out.req   = (state == CH_FETCH) || (state == CH_READ) ||
                         (state == CH_WRITE && !rom_hit);
        port_out.we    = (state == CH_WRITE);
        port_out.space = (state == CH_READ) ? src_pci : (state == CH_WRITE) ? dst_pci : 1'b0;
        case (state)
            CH_FETCH: port_out.addr = dbase + {28'd0, fidx, 2'b00};
            CH_READ:  port_out.addr = {src[31:2], 2'b00};
            default:  port_out.addr = {dst[31:2], 2'b00};
        endcase
        port_out.be    = (state == CH_WRITE) ? sh_be : 4'hF;
        port_out.wdata = sh_data;
    end

    always_comb begin
        case (cfg_sel)
            REG_CTRL:  cfg_rdata = {28'd0, dst_pci, src_pci, chain_mode, 1'b0};
            REG_SRC:   cfg_rdata = src;
            REG_DST:   cfg_rdata = dst;
            REG_NEXT:  cfg_rdata = nxt;
            REG_COUNT: cfg_rdata = cnt;
            REG_STAT:  cfg_rdata = {28'd0, st_err, st_chain, st_seg, busy};
            default:   cfg_rdata = 32'd0;
        endcase
    end

    assign irq_seg   = st_seg;
    assign irq_chain = st_chain;
    assign irq_err   = st_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CH_IDLE;
            {src, dst, nxt, cnt, dbase, hold} <= '0;
            {chain_mode, src_pci, dst_pci, busy} <= '0;
            {st_seg, st_chain, st_err} <= '0;
            fidx <= '0;
        end else begin
            if (cfg_wr) begin
                if (cfg_sel == REG_STAT) begin
                    if (cfg_wdata[1]) st_seg   <= 1'b0;
                    if (cfg_wdata[2]) st_chain <= 1'b0;
                    if (cfg_wdata[3]) st_err   <= 1'b0;
                end else if (!busy) begin
                    case (cfg_sel)
                        REG_CTRL: begin
                            chain_mode <= cfg_wdata[1];
                            src_pci    <= cfg_wdata[2];
                            dst_pci    <= cfg_wdata[3];
                            if (cfg_wdata[0]) begin
                                busy  <= 1'b1;
                                fidx  <= 2'd0;
                                dbase <= {nxt[31:2], 2'b00};
                                state <= cfg_wdata[1] ? CH_FETCH : CH_SEG;
                            end
                        end
                        REG_SRC:   src <= cfg_wdata;
                        REG_DST:   dst <= cfg_wdata;
                        REG_NEXT:  nxt <= cfg_wdata;
                        REG_COUNT: cnt <= cfg_wdata;
                        default: ;
                    endcase
                end
            end
            case (state)
                CH_FETCH: if (port_gnt) begin
                    case (fidx)
                        2'd0: src <= port_rdata;
                        2'd1: dst <= port_rdata;
                        2'd2: nxt <= port_rdata;
                        default: cnt <= port_rdata;
                    endcase
                    fidx <= fidx + 2'd1;
                    if (fidx == 2'd3) state <= CH_SEG;
                end
                CH_SEG: state <= (cnt == 32'd0) ? CH_END : CH_READ;
                CH_READ: if (port_gnt) begin
                    hold  <= port_rdata;
                    state <= CH_WRITE;
                end
                CH_WRITE: begin
                    if (rom_hit) begin
                        st_err <= 1'b1;
                        busy   <= 1'b0;
                        state  <= CH_IDLE;
                    end else if (port_gnt) begin
                        src <= src + 32'(step_n);
                        dst <= dst + 32'(step_n);
                        cnt <= cnt - 32'(step_n);
                        state <= (cnt == 32'(step_n)) ? CH_END : CH_READ;
                    end
                end
                CH_END: begin
                    st_seg <= 1'b1;
                    if (chain_mode && !nxt[0]) begin
                        dbase <= {nxt[31:2], 2'b00};
                        fidx  <= 2'd0;
                        state <= CH_FETCH;
                    end else begin
                        busy  <= 1'b0;
                        state <= CH_IDLE;
                        if (chain_mode) st_chain <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    a_r6_no_rom_write: assert property (@(posedge clk) disable iff (rst)
        !(port_out.req && port_out.we && !port_out.space &&
          in_window(port_out.addr, ROM_BASE, ROM_SIZE)));
    a_r6_err_stops: assert property (@(posedge clk) disable iff (rst)
        $rose(st_err) |-> !busy);
    a_r11_lanes: assert property (@(posedge clk) disable iff (rst)
        (port_out.req && port_out.we) |-> (port_out.be != 4'h0));
    a_r8_zero_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == CH_SEG && cnt == 32'd0) |=> !port_out.req);
    a_r7_busy_ctrl: assert property (@(posedge clk) disable iff (rst)
        (busy && cfg_wr && cfg_sel == REG_CTRL) |=> (chain_mode == $past(chain_mode)));
endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter logic [31:0] ROM_BASE = 32'hFF00_0000,
    parameter logic [31:0] ROM_SIZE = 32'h0100_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic        mem_space,
    output logic [31:0] mem_addr,
    output logic [3:0]  mem_be,
    output logic [31:0] mem_wdata,
    input  logic        mem_gnt,
    input  logic [31:0] mem_rdata,
    output logic [1:0]  irq_seg,
    output logic [1:0]  irq_chain,
    output logic [1:0]  irq_err
);
    localparam int NCH = 2;

    port_req_t   ch_port [NCH];
    logic [31:0] ch_rd   [NCH];
    logic [NCH-1:0] ch_req, sel;
    port_req_t   pick;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dma_channel #(.ROM_BASE(ROM_BASE), .ROM_SIZE(ROM_SIZE)) ch_i (
            .clk(clk), .rst(rst),
            .cfg_wr(reg_wr && (reg_addr[3] == 1'(g))),
            .cfg_sel(reg_addr[2:0]), .cfg_wdata(reg_wdata), .cfg_rdata(ch_rd[g]),
            .port_gnt(mem_gnt && sel[g]), .port_rdata(mem_rdata),
            .port_out(ch_port[g]),
            .irq_seg(irq_seg[g]), .irq_chain(irq_chain[g]), .irq_err(irq_err[g])
        );
        assign ch_req[g] = ch_port[g].req;
    end

    dma_rr_arb arb_i (.clk(clk), .rst(rst), .req(ch_req), .port_gnt(mem_gnt), .sel(sel));

    assign pick      = sel[1] ? ch_port[1] : ch_port[0];
    assign mem_req   = |sel;
    assign mem_we    = pick.we;
    assign mem_space = pick.space;
    assign mem_addr  = pick.addr;
    assign mem_be    = pick.be;
    assign mem_wdata = pick.wdata;
    assign reg_rdata = ch_rd[reg_addr[3]];
endmodule

// File: tb/dma_engine_tb_top.sv
`timescale 1ns/1ps
module dma_engine_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_space;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  mem_be;
    logic        mem_gnt = 1'b0;
    logic [1:0]  irq_seg, irq_chain, irq_err;

    dma_engine #(.ROM_BASE(32'h300), .ROM_SIZE(32'h100)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_space(mem_space),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .irq_seg(irq_seg), .irq_chain(irq_chain), .irq_err(irq_err)
    );

    logic [31:0] loc_m [256];
    logic [31:0] pci_m [256];
    logic [31:0] exp_loc [256];
    logic [31:0] exp_pci [256];
    logic        poke_en = 1'b0;
    logic [7:0]  poke_a = 8'd0;
    logic [31:0] poke_d = 32'd0;

    assign mem_rdata = mem_space ? pci_m[mem_addr[9:2]] : loc_m[mem_addr[9:2]];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) begin
                loc_m[i] <= 32'h1000_0000 + 32'(i) * 32'h0301_0705;
                pci_m[i] <= 32'hC000_0000 ^ (32'(i) * 32'h0107_0B0D);
            end
        end else begin
            if (poke_en) loc_m[poke_a] <= poke_d;
            if (mem_req && mem_gnt && mem_we) begin
                for (int b = 0; b < 4; b++) begin
                    if (mem_be[b]) begin
                        if (mem_space) pci_m[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                        else           loc_m[mem_addr[9:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
                    end
                end
            end
        end
    end

    int gcnt = 0;
    always @(negedge clk) begin
        gcnt = gcnt + 1;
        mem_gnt <= (gcnt % 4) != 0;
    end

    int req_cycles = 0, switches = 0, zero_be = 0, partial_wr = 0;
    logic last_reg = 1'b0;
    always @(posedge clk) begin
        if (!rst) begin
            if (mem_req) req_cycles = req_cycles + 1;
            if (mem_req && mem_gnt) begin
                if (mem_addr[8] != last_reg) switches = switches + 1;
                last_reg = mem_addr[8];
                if (mem_we && mem_be == 4'h0) zero_be = zero_be + 1;
                if (mem_we && mem_be != 4'hF) partial_wr = partial_wr + 1;
            end
        end
    end

    int checks = 0, fails = 0, cyc = 0;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            checks = checks + 1;
            fails = fails + 1;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic reg_write(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a);
        #1 d = reg_rdata;
    endtask

    task automatic poke(input int byte_addr, input logic [31:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_a = 8'(byte_addr >> 2); poke_d = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic wait_idle(input int ch);
        logic [31:0] d;
        for (int k = 0; k < 5000; k++) begin
            reg_read(ch * 8 + 5, d);
            if (!d[0]) break;
        end
    endtask

    task automatic snap();
        @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            exp_loc[i] = loc_m[i];
            exp_pci[i] = pci_m[i];
        end
    endtask

    function automatic logic [7:0] eb(input bit sp, input int a);
        int w = (a >> 2) & 255;
        int l = a % 4;
        return sp ? exp_pci[w][8*l +: 8] : exp_loc[w][8*l +: 8];
    endfunction

    task automatic ewr(input bit sp, input int a, input logic [7:0] v);
        int w = (a >> 2) & 255;
        int l = a % 4;
        if (sp) exp_pci[w][8*l +: 8] = v;
        else    exp_loc[w][8*l +: 8] = v;
    endtask

    task automatic exp_copy(input bit ss, input int s, input bit ds, input int d, input int n);
        for (int i = 0; i < n; i++) ewr(ds, d + i, eb(ss, s + i));
    endtask

    task automatic cmp_mem(input string rq);
        int bl = -1, bp = -1;
        for (int i = 0; i < 256; i++) begin
            if (bl < 0 && loc_m[i] !== exp_loc[i]) bl = i;
            if (bp < 0 && pci_m[i] !== exp_pci[i]) bp = i;
        end
        chk(bl < 0, {rq, " local mem"}, bl < 0 ? 32'd0 : loc_m[bl], bl < 0 ? 32'd0 : exp_loc[bl]);
        chk(bp < 0, {rq, " pci mem"},   bp < 0 ? 32'd0 : pci_m[bp], bp < 0 ? 32'd0 : exp_pci[bp]);
    endtask

    task automatic clr_all();
        reg_write(5, 32'hE);
        reg_write(13, 32'hE);
    endtask

    task automatic prog(input int ch, input int s, input int d, input int n);
        reg_write(ch * 8 + 1, 32'(s));
        reg_write(ch * 8 + 2, 32'(d));
        reg_write(ch * 8 + 4, 32'(n));
    endtask

    task automatic run_direct(input int ch, input bit ss, input int s, input bit ds, input int d,
                              input int n, input string rq);
        logic [31:0] st;
        clr_all();
        snap();
        prog(ch, s, d, n);
        reg_write(ch * 8, {28'd0, ds, ss, 2'b01});
        wait_idle(ch);
        exp_copy(ss, s, ds, d, n);
        cmp_mem(rq);
        reg_read(ch * 8 + 5, st);
        chk(st == 32'h2, {rq, " status seg only (R10)"}, st, 32'h2);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_read(5, d);  chk(d == 0, "R1 ch0 status", d, 0);
        reg_read(13, d); chk(d == 0, "R1 ch1 status", d, 0);
        chk({irq_seg, irq_chain, irq_err} == 0, "R1 irq lines", 32'({irq_seg, irq_chain, irq_err}), 0);
        chk(mem_req == 0, "R1 mem_req", 32'(mem_req), 0);
    endtask

    task automatic t_regmap_aligned();
        logic [31:0] d;
        prog(0, 32'h040, 32'h080, 16);
        reg_read(1, d); chk(d == 32'h40, "R2 src readback", d, 32'h40);
        reg_read(2, d); chk(d == 32'h80, "R2 dst readback", d, 32'h80);
        reg_read(4, d); chk(d == 16, "R2 count readback", d, 16);
        run_direct(0, 1'b0, 32'h040, 1'b1, 32'h080, 16, "R3 local->pci aligned");
        chk(irq_seg[0] && !irq_chain[0], "R10 irq seg without chain", 32'({irq_seg, irq_chain}), 32'h4);
        reg_write(5, 32'h2);
        reg_read(5, d); chk(d == 0, "R9 w1c seg", d, 0);
    endtask

    task automatic t_misaligned();
        int p0 = partial_wr;
        run_direct(1, 1'b1, 32'h0A3, 1'b0, 32'h005, 13, "R4 pci->local misaligned");
        chk(partial_wr > p0, "R11 partial byte enables used", 32'(partial_wr - p0), 1);
        run_direct(0, 1'b1, 32'h011, 1'b1, 32'h1C6, 9, "R3 pci->pci");
        run_direct(1, 1'b0, 32'h020, 1'b0, 32'h203, 7, "R3 local->local");
        run_direct(0, 1'b0, 32'h0C2, 1'b1, 32'h0E2, 1, "R4 single byte");
    endtask

    task automatic t_zero();
        int r0;
        logic [31:0] st;
        clr_all();
        snap();
        prog(0, 32'h010, 32'h200, 0);
        r0 = req_cycles;
        reg_write(0, 32'h1);
        wait_idle(0);
        chk(req_cycles == r0, "R8 no access on zero count", 32'(req_cycles - r0), 0);
        reg_read(5, st);
        chk(st == 32'h2, "R8 zero count seg done", st, 32'h2);
        cmp_mem("R8 memory untouched");
    endtask

    task automatic t_rom();
        logic [31:0] st;
        clr_all();
        snap();
        prog(1, 32'h000, 32'h310, 8);
        reg_write(8, 32'h1);
        wait_idle(1);
        reg_read(13, st);
        chk(st == 32'h8, "R6 rom start err", st, 32'h8);
        chk(irq_err[1] == 1'b1, "R10 irq_err", 32'(irq_err), 32'h2);
        cmp_mem("R6 rom untouched");
        clr_all();
        snap();
        prog(1, 32'h010, 32'h2FE, 6);
        reg_write(8, 32'h1);
        wait_idle(1);
        exp_copy(1'b0, 32'h010, 1'b0, 32'h2FE, 2);
        reg_read(13, st);
        chk(st == 32'h8, "R6 rom partway err", st, 32'h8);
        cmp_mem("R6 bytes before rom kept");
    endtask

    task automatic t_busy_ignore();
        logic [31:0] st;
        clr_all();
        snap();
        prog(0, 32'h000, 32'h200, 64);
        reg_write(0, 32'h9);
        reg_write(1, 32'h123);
        reg_write(0, 32'h3);
        wait_idle(0);
        exp_copy(1'b0, 32'h000, 1'b1, 32'h200, 64);
        cmp_mem("R7 transfer unaffected");
        reg_read(0, st);
        chk(st == 32'h8, "R7 ctrl write ignored", st, 32'h8);
        reg_read(5, st);
        chk(st == 32'h2, "R7 no chain started", st, 32'h2);
    endtask

    task automatic t_chain();
        logic [31:0] st;
        poke(32'h200, 32'h041); poke(32'h204, 32'h103); poke(32'h208, 32'h210); poke(32'h20C, 10);
        poke(32'h210, 32'h000); poke(32'h214, 32'h000); poke(32'h218, 32'h220); poke(32'h21C, 0);
        poke(32'h220, 32'h0F2); poke(32'h224, 32'h150); poke(32'h228, 32'h001); poke(32'h22C, 5);
        clr_all();
        snap();
        reg_write(3, 32'h200);
        reg_write(0, 32'hB);
        wait_idle(0);
        exp_copy(1'b0, 32'h041, 1'b1, 32'h103, 10);
        exp_copy(1'b0, 32'h0F2, 1'b1, 32'h150, 5);
        cmp_mem("R5 chained scatter-gather");
        reg_read(5, st);
        chk(st == 32'h6, "R5 chain and seg done", st, 32'h6);
        chk(irq_chain[0] == 1'b1, "R10 irq_chain", 32'(irq_chain), 32'h1);
        reg_write(5, 32'h5);
        reg_read(5, st);
        chk(st == 32'h2, "R9 selective w1c, busy read-only", st, 32'h2);
    endtask

    task automatic t_concurrent();
        logic [31:0] s0, s1;
        int sw0;
        clr_all();
        snap();
        prog(0, 32'h000, 32'h000, 64);
        prog(1, 32'h100, 32'h100, 64);
        sw0 = switches;
        reg_write(0, 32'h9);
        reg_write(8, 32'h9);
        wait_idle(0);
        wait_idle(1);
        exp_copy(1'b0, 32'h000, 1'b1, 32'h000, 64);
        exp_copy(1'b0, 32'h100, 1'b1, 32'h100, 64);
        cmp_mem("R12 both channels");
        chk((switches - sw0) >= 16, "R12 grants interleave", 32'(switches - sw0), 16);
        reg_read(5, s0); reg_read(13, s1);
        chk(s0 == 2 && s1 == 2, "R12 both seg done", {s0[15:0], s1[15:0]}, 32'h0002_0002);
        chk(zero_be == 0, "R11 no empty write enables", 32'(zero_be), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regmap_aligned();
        t_misaligned();
        t_zero();
        t_rom();
        t_busy_ignore();
        t_chain();
        t_concurrent();
        summary();
    end
endmodule